// File: doc/BRIEF.md
# Video Capture Line Address Generator

This block computes the memory start addresses at which a video capture path writes each incoming line. It serves two buffer layouts. In the single-buffer layout, one luma/linear address advances by the video pitch. In the planar layout, a Y address advances by the video pitch and separate U and V addresses advance by the chroma pitch. The capture timing logic supplies frame, field and line strobes and a field parity bit. At every field or frame start the three line cursors restart from a base address picked by parity.

Software programs six base addresses: odd and even for each of Y, U and V. The block keeps working copies of them, and a control bit sets when those copies reload. They can reload on every field or only on frame starts. Another control bit puts the even-field chroma buffers on the odd-field chroma bases. A FIFO overflow input is handled in one of two ways. The block can recover by itself, dropping the rest of the line. Or it can raise an interrupt and freeze until a FIFO reset.

Top module: `vcap_line_addr`

## Requirements
- R1: After reset all address outputs, `line_valid` and `ovf_irq` are 0. The pitches and all control bits are 0, so line starts issued before any programming leave the Y address at 0.
- R2: A write on `pitch_wr` takes the Y pitch from `pitch_data[15:0]` and the UV pitch from `pitch_data[31:16]`. The low five bits of each pitch are stored as zero.
- R3: The address outputs update on the clock edge that samples `line_start`. Each later line start adds the Y pitch to the Y output and the UV pitch to the U and V outputs.
- R4: With control bit 1 (planar) at 0, the U and V outputs stay 0 and only the Y address steps.
- R5: A `field_start` or `frame_start` makes the next line begin at the selected base. `field_odd`=1 selects the odd bases and 0 selects the even bases.
- R6: With control bit 0 (interlaced) at 1 and control bit 2 (field reload) at 0, the working bases copy the programmed base inputs only on `frame_start`. A `field_start` alone restarts from the held copies.
- R7: With control bits 0 and 2 both at 1, the working bases reload from the inputs on every `field_start`.
- R8: With control bit 0 at 0, every `field_start` reloads the working bases, whatever the value of bit 2.
- R9: With control bit 3 at 1, even fields take their U and V bases from the odd-field U and V bases. The Y base still follows parity.
- R10: With control bit 4 at 0, `fifo_ovf` clears `line_valid` without raising `ovf_irq`. The next line start sets `line_valid` again at the next address in sequence.
- R11: With control bit 4 at 1, `fifo_ovf` sets `ovf_irq` and clears `line_valid`. While `ovf_irq` is set, line starts are ignored and the addresses hold. A pulse on `fifo_reset` clears `ovf_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pitch_wr | input | 1 | Pitch register write strobe |
| pitch_data | input | 32 | UV pitch in 31:16, Y pitch in 15:0 |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_data | input | 5 | Bit 0 interlaced, 1 planar, 2 field reload, 3 chroma on odd base, 4 recovery disable |
| base_y_odd | input | 32 | Programmed odd-field Y base |
| base_y_even | input | 32 | Programmed even-field Y base |
| base_u_odd | input | 32 | Programmed odd-field U base |
| base_u_even | input | 32 | Programmed even-field U base |
| base_v_odd | input | 32 | Programmed odd-field V base |
| base_v_even | input | 32 | Programmed even-field V base |
| frame_start | input | 1 | Frame start strobe |
| field_start | input | 1 | Field start strobe |
| field_odd | input | 1 | Parity of the starting field, 1 = odd |
| line_start | input | 1 | Line start strobe |
| fifo_ovf | input | 1 | FIFO overflow pulse |
| fifo_reset | input | 1 | Software FIFO reset pulse |
| y_addr | output | 32 | Current Y / linear line start address |
| u_addr | output | 32 | Current U line start address |
| v_addr | output | 32 | Current V line start address |
| line_valid | output | 1 | Current line may be written |
| ovf_irq | output | 1 | Overflow interrupt, held until FIFO reset |

## Verification
The assertions assume that the strobes are single-cycle pulses and that `fifo_ovf` does not arrive in the same cycle as `line_start`. The pitch step property also assumes that no pitch write falls between two line starts it compares. The bench drives each strobe for exactly one cycle with idle cycles between strobes. It writes registers only before a field or frame start, never inside a chain of lines.

// File: rtl/vcap_pkg.sv
// Package: shared types and constants for the capture line address generator.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package vcap_pkg;

    // Number of address planes (Y, U, V) and pitch alignment in bits.
    localparam int NPLANE     = 3;
    localparam int ALIGN_BITS = 5;

    // Control register layout; first member is the most significant bit.
    typedef struct packed {
        logic no_recover;    // bit 4
        logic uv_on_odd;     // bit 3
        logic field_reload;  // bit 2
        logic planar;        // bit 1
        logic interlaced;    // bit 0
    } vcap_ctrl_t;

endpackage

// File: rtl/vcap_cfg_regs.sv
// Module: holds the pitch pair and the control bits written by software.
// Assumes: write strobes are single-cycle; pitches are aligned on write.
module vcap_cfg_regs
    import vcap_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pitch_wr,
    input  logic [2*PW-1:0] pitch_data,
    input  logic            ctrl_wr,
    input  logic [4:0]      ctrl_data,
    output logic [PW-1:0]   y_pitch,
    output logic [PW-1:0]   uv_pitch,
    output vcap_ctrl_t      ctrl
);

    localparam logic [PW-1:0] ALIGN_MASK = ~((PW)'((1 << ALIGN_BITS) - 1));

    // Capture pitch writes, clearing the alignment bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_pitch  <= '0;
            uv_pitch <= '0;
        end else if (pitch_wr) begin
            y_pitch  <= pitch_data[PW-1:0] & ALIGN_MASK;
            uv_pitch <= pitch_data[2*PW-1:PW] & ALIGN_MASK;
        end
    end

    // Capture control writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl <= '0;
        else if (ctrl_wr) ctrl <= vcap_ctrl_t'(ctrl_data);
    end

endmodule

// File: rtl/vcap_base_shadow.sv
// Module: working copies of the odd/even bases per plane and the parity mux.
// Assumes: plane 0 is Y; planes above 0 are chroma. When reload is high the
// freshly programmed bases are selected in the same cycle.
module vcap_base_shadow
    import vcap_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reload,
    input  logic                     field_odd,
    input  logic                     uv_on_odd,
    input  logic [NPLANE-1:0][AW-1:0] prog_odd,
    input  logic [NPLANE-1:0][AW-1:0] prog_even,
    output logic [NPLANE-1:0][AW-1:0] sel_base
);

    for (genvar p = 0; p < NPLANE; p++) begin : g_plane
        logic [AW-1:0] work_odd, work_even;
        logic [AW-1:0] src_odd, src_even;
        logic          use_odd;

        // Refresh the working copies on a reload event.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                work_odd  <= '0;
                work_even <= '0;
            end else if (reload) begin
                work_odd  <= prog_odd[p];
                work_even <= prog_even[p];
            end
        end

        // Pick the base for the starting field.
        always_comb begin
            src_odd     = reload ? prog_odd[p]  : work_odd;
            src_even    = reload ? prog_even[p] : work_even;
            use_odd     = field_odd || ((p != 0) && uv_on_odd);
            sel_base[p] = use_odd ? src_odd : src_even;
        end
    end

endmodule

// File: rtl/vcap_line_cursor.sv
// Module: per-plane line cursor; emits the line start address and advances
// by the pitch. Assumes AW > PW; a restart in the same cycle as a line start
// makes that line begin at the new base.
module vcap_line_cursor #(
    parameter int AW = 32,
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [AW-1:0] base,
    input  logic          line_go,
    input  logic [PW-1:0] pitch,
    input  logic          enable,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] cur, start;

    // Choose the address the next line starts from.
    always_comb start = restart ? base : cur;

    // Publish the line address and step the cursor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur  <= '0;
            addr <= '0;
        end else if (line_go) begin
            addr <= enable ? start : '0;
            cur  <= start + {{(AW-PW){1'b0}}, pitch};
        end else if (restart) begin
            cur <= base;
        end
    end

endmodule

// File: rtl/vcap_ovf_ctrl.sv
// Module: overflow handling: drops the line, or halts and interrupts
// until a FIFO reset. Assumes single-cycle strobes.
module vcap_ovf_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic no_recover,
    input  logic fifo_ovf,
    input  logic fifo_reset,
    input  logic line_start,
    output logic line_valid,
    output logic ovf_irq
);

    // Track line validity and the sticky overflow interrupt.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_valid <= 1'b0;
            ovf_irq    <= 1'b0;
        end else if (ovf_irq) begin
            line_valid <= 1'b0;
            if (fifo_reset) ovf_irq <= 1'b0;
        end else if (fifo_ovf) begin
            line_valid <= 1'b0;
            ovf_irq    <= no_recover;
        end else if (line_start) begin
            line_valid <= 1'b1;
        end
    end

endmodule

// File: rtl/vcap_line_addr.sv
// Module: top of the capture line address generator. Combines config,
// base shadowing, three plane cursors and overflow control.
// Assumes: strobes from capture timing are single-cycle pulses.
module vcap_line_addr
    import vcap_pkg::*;
#(
    parameter int AW = 32,
    parameter int PW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pitch_wr,
    input  logic [2*PW-1:0] pitch_data,
    input  logic            ctrl_wr,
    input  logic [4:0]      ctrl_data,
    input  logic [AW-1:0]   base_y_odd,
    input  logic [AW-1:0]   base_y_even,
    input  logic [AW-1:0]   base_u_odd,
    input  logic [AW-1:0]   base_u_even,
    input  logic [AW-1:0]   base_v_odd,
    input  logic [AW-1:0]   base_v_even,
    input  logic            frame_start,
    input  logic            field_start,
    input  logic            field_odd,
    input  logic            line_start,
    input  logic            fifo_ovf,
    input  logic            fifo_reset,
    output logic [AW-1:0]   y_addr,
    output logic [AW-1:0]   u_addr,
    output logic [AW-1:0]   v_addr,
    output logic            line_valid,
    output logic            ovf_irq
);

    logic [PW-1:0]             y_pitch, uv_pitch;
    vcap_ctrl_t                ctrl_q;
    logic                      reload, restart, line_go;
    logic [NPLANE-1:0][AW-1:0] prog_odd, prog_even, sel_base, addr_arr;

    vcap_cfg_regs #(.PW(PW)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .pitch_wr(pitch_wr), .pitch_data(pitch_data),
        .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
        .y_pitch(y_pitch), .uv_pitch(uv_pitch), .ctrl(ctrl_q)
    );

    // Decode restart and reload events from the timing strobes.
    always_comb begin
        restart = frame_start || field_start;
        reload  = frame_start ||
                  (field_start && (!ctrl_q.interlaced || ctrl_q.field_reload));
        line_go = line_start && !ovf_irq;
    end

    // Gather the programmed bases per plane.
    always_comb begin
        prog_odd  = {base_v_odd,  base_u_odd,  base_y_odd};
        prog_even = {base_v_even, base_u_even, base_y_even};
    end

    vcap_base_shadow #(.AW(AW)) u_shadow (
        .clk(clk), .rst_n(rst_n), .reload(reload), .field_odd(field_odd),
        .uv_on_odd(ctrl_q.uv_on_odd), .prog_odd(prog_odd),
        .prog_even(prog_even), .sel_base(sel_base)
    );

    for (genvar p = 0; p < NPLANE; p++) begin : g_cur
        localparam bit IS_Y = (p == 0);
        vcap_line_cursor #(.AW(AW), .PW(PW)) u_cur (
            .clk(clk), .rst_n(rst_n), .restart(restart),
            .base(sel_base[p]), .line_go(line_go),
            .pitch(IS_Y ? y_pitch : uv_pitch),
            .enable(IS_Y ? 1'b1 : ctrl_q.planar),
            .addr(addr_arr[p])
        );
    end

    vcap_ovf_ctrl u_ovf (
        .clk(clk), .rst_n(rst_n), .no_recover(ctrl_q.no_recover),
        .fifo_ovf(fifo_ovf), .fifo_reset(fifo_reset),
        .line_start(line_start), .line_valid(line_valid), .ovf_irq(ovf_irq)
    );

    // Route plane addresses to the outputs.
    always_comb begin
        y_addr = addr_arr[0];
        u_addr = addr_arr[1];
        v_addr = addr_arr[2];
    end

endmodule

// File: rtl/vcap_line_addr_chk.sv
// Checker: temporal properties of the line address generator, bound to the top.
// Assumes single-cycle strobes and no overflow in a line start cycle.
module vcap_line_addr_chk #(
    parameter int AW = 32,
    parameter int PW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          line_start,
    input logic          field_start,
    input logic          frame_start,
    input logic          pitch_wr,
    input logic          fifo_ovf,
    input logic          fifo_reset,
    input logic          ctrl_planar,
    input logic          ctrl_no_recover,
    input logic [PW-1:0] y_pitch,
    input logic [AW-1:0] y_addr,
    input logic [AW-1:0] u_addr,
    input logic [AW-1:0] v_addr,
    input logic          line_valid,
    input logic          ovf_irq
);

    logic chain;
    logic go, rst_evt;

    always_comb begin
        go      = line_start && !ovf_irq;
        rst_evt = field_start || frame_start;
    end

    // Remember whether the last output came from an unbroken line chain.
    always_ff @(posedge clk) begin
        if (!rst_n)                 chain <= 1'b0;
        else if (go)                chain <= !pitch_wr;
        else if (rst_evt || pitch_wr) chain <= 1'b0;
    end

    p_line_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (go && chain && !rst_evt && !pitch_wr) |=>
            y_addr == $past(y_addr) + {{(AW-PW){1'b0}}, $past(y_pitch)});

    p_linear_uv_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !ctrl_planar) |=> (u_addr == '0 && v_addr == '0));

    p_auto_recover_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_ovf && !ovf_irq && !ctrl_no_recover && !line_start) |=>
            (!line_valid && !ovf_irq));

    p_halt_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_irq && !fifo_reset) |=> (ovf_irq && !line_valid));

    p_halt_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_irq && line_start) |=> $stable(y_addr));

    p_line_resume_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !ovf_irq && !fifo_ovf) |=> line_valid);

endmodule

bind vcap_line_addr vcap_line_addr_chk #(.AW(AW), .PW(PW)) u_chk (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .field_start(field_start), .frame_start(frame_start),
    .pitch_wr(pitch_wr), .fifo_ovf(fifo_ovf), .fifo_reset(fifo_reset),
    .ctrl_planar(ctrl_q.planar), .ctrl_no_recover(ctrl_q.no_recover),
    .y_pitch(y_pitch), .y_addr(y_addr), .u_addr(u_addr), .v_addr(v_addr),
    .line_valid(line_valid), .ovf_irq(ovf_irq)
);

// File: tb/sim_vcap_line_addr.sv
`timescale 1ns/1ps
module sim_vcap_line_addr;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pitch_wr = 1'b0, ctrl_wr = 1'b0;
    logic [31:0] pitch_data = '0;
    logic [4:0]  ctrl_data = '0;
    logic [31:0] b_yo = 32'h1000_0000, b_ye = 32'h2000_0000;
    logic [31:0] b_uo = 32'h3000_0000, b_ue = 32'h4000_0000;
    logic [31:0] b_vo = 32'h5000_0000, b_ve = 32'h6000_0000;
    logic        frame_start = 1'b0, field_start = 1'b0, field_odd = 1'b0;
    logic        line_start = 1'b0, fifo_ovf = 1'b0, fifo_reset = 1'b0;
    logic [31:0] y_addr, u_addr, v_addr;
    logic        line_valid, ovf_irq;

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] YP = 32'h0000_5660;
    localparam logic [31:0] UP = 32'h0000_1220;

    always #2.5 clk = ~clk;

    vcap_line_addr u0 (
        .clk(clk), .rst_n(rst_n), .pitch_wr(pitch_wr), .pitch_data(pitch_data),
        .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
        .base_y_odd(b_yo), .base_y_even(b_ye), .base_u_odd(b_uo),
        .base_u_even(b_ue), .base_v_odd(b_vo), .base_v_even(b_ve),
        .frame_start(frame_start), .field_start(field_start),
        .field_odd(field_odd), .line_start(line_start),
        .fifo_ovf(fifo_ovf), .fifo_reset(fifo_reset),
        .y_addr(y_addr), .u_addr(u_addr), .v_addr(v_addr),
        .line_valid(line_valid), .ovf_irq(ovf_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one strobe cycle, then release; outputs are settled on return.
    task automatic pulse(input bit fr, input bit fd, input bit ln,
                         input bit ov, input bit fr_rst);
        @(negedge clk);
        frame_start = fr; field_start = fd; line_start = ln;
        fifo_ovf = ov; fifo_reset = fr_rst;
        @(negedge clk);
        frame_start = 0; field_start = 0; line_start = 0;
        fifo_ovf = 0; fifo_reset = 0;
    endtask

    task automatic wr_ctrl(input logic [4:0] v);
        @(negedge clk); ctrl_wr = 1; ctrl_data = v;
        @(negedge clk); ctrl_wr = 0;
    endtask

    task automatic wr_pitch(input logic [31:0] v);
        @(negedge clk); pitch_wr = 1; pitch_data = v;
        @(negedge clk); pitch_wr = 0;
    endtask

    task automatic line();         pulse(0, 0, 1, 0, 0); endtask
    task automatic frame(input bit odd); field_odd = odd; pulse(1, 1, 0, 0, 0); endtask
    task automatic field(input bit odd); field_odd = odd; pulse(0, 1, 0, 0, 0); endtask

    task automatic t_reset;
        chk("R1 y", y_addr, 0); chk("R1 u", u_addr, 0); chk("R1 v", v_addr, 0);
        chk("R1 valid", {31'b0, line_valid}, 0); chk("R1 irq", {31'b0, ovf_irq}, 0);
        line(); line();
        chk("R1 zero pitch", y_addr, 0);
    endtask

    task automatic t_planar;
        wr_pitch(32'h1234_5678);
        wr_ctrl(5'h03);
        frame(1); line();
        chk("R5 y odd", y_addr, b_yo); chk("R5 u odd", u_addr, b_uo);
        chk("R5 v odd", v_addr, b_vo);
        line();
        chk("R2 R3 y step", y_addr, b_yo + YP);
        chk("R2 R3 u step", u_addr, b_uo + UP);
        chk("R3 v step", v_addr, b_vo + UP);
        line();
        chk("R3 y step2", y_addr, b_yo + 2*YP);
    endtask

    task automatic t_even;
        field(0); line();
        chk("R5 y even", y_addr, b_ye); chk("R5 u even", u_addr, b_ue);
        chk("R5 v even", v_addr, b_ve);
    endtask

    task automatic t_frame_reload;
        b_yo = 32'h1100_0000;
        field(1); line();
        chk("R6 held base", y_addr, 32'h1000_0000);
        frame(1); line();
        chk("R6 frame reload", y_addr, 32'h1100_0000);
    endtask

    task automatic t_field_reload;
        wr_ctrl(5'h07);
        b_yo = 32'h1200_0000;
        field(1); line();
        chk("R7 field reload", y_addr, 32'h1200_0000);
    endtask

    task automatic t_progressive;
        wr_ctrl(5'h02);
        b_yo = 32'h1300_0000;
        field(1); line();
        chk("R8 progressive reload", y_addr, 32'h1300_0000);
    endtask

    task automatic t_uv_odd;
        wr_ctrl(5'h0B);
        frame(0); line();
        chk("R9 y even", y_addr, b_ye);
        chk("R9 u from odd", u_addr, b_uo);
        chk("R9 v from odd", v_addr, b_vo);
    endtask

    task automatic t_linear;
        wr_ctrl(5'h01);
        frame(1); line();
        chk("R4 y", y_addr, b_yo); chk("R4 u", u_addr, 0); chk("R4 v", v_addr, 0);
        line();
        chk("R4 y step", y_addr, b_yo + YP); chk("R4 u still", u_addr, 0);
    endtask

    task automatic t_auto;
        wr_ctrl(5'h03);
        frame(1); line();
        chk("R10 valid", {31'b0, line_valid}, 1);
        pulse(0, 0, 0, 1, 0);
        chk("R10 dropped", {31'b0, line_valid}, 0);
        chk("R10 no irq", {31'b0, ovf_irq}, 0);
        line();
        chk("R10 resume valid", {31'b0, line_valid}, 1);
        chk("R10 next addr", y_addr, b_yo + YP);
    endtask

    task automatic t_halt;
        wr_ctrl(5'h13);
        frame(1); line();
        pulse(0, 0, 0, 1, 0);
        chk("R11 irq", {31'b0, ovf_irq}, 1);
        chk("R11 invalid", {31'b0, line_valid}, 0);
        line();
        chk("R11 hold addr", y_addr, b_yo);
        chk("R11 still invalid", {31'b0, line_valid}, 0);
        pulse(0, 0, 0, 0, 1);
        chk("R11 irq cleared", {31'b0, ovf_irq}, 0);
        line();
        chk("R11 resume addr", y_addr, b_yo + YP);
        chk("R11 resume valid", {31'b0, line_valid}, 1);
    endtask

    bit done = 0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_planar();
        t_even();
        t_frame_reload();
        t_field_reload();
        t_progressive();
        t_uv_odd();
        t_linear();
        t_auto();
        t_halt();
        done = 1;
    end

    initial begin
        for (int i = 0; i < 20000 && !done; i++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule